// File: doc/BRIEF.md
# Endpoint DMA Request Register Bank

This block holds one DMA request flag per endpoint of a USB device controller, 32 flags in all. The endpoint logic raises a flag when a packet arrives for an endpoint whose slave interrupt is disabled. The flag drops again when the DMA engine reports that a packet transfer for a DMA-enabled endpoint has finished. The flag vector goes straight to the DMA engine.

Software reaches the bank through a small register bus with three locations. The status location reads the flag vector. The clear and set locations are write-only. Writing ones at either location clears or sets the matching flags and leaves every other flag alone. The set path lets software start a transfer by hand after moving an endpoint from slave to DMA operation. A packet that arrived while the interrupt enable was still on raised no request, so software raises it here. The two control endpoints, bits 0 and 1, can never hold a request.

Top module: `edr_top`

## Requirements
- R1: After reset every status bit is 0, and both the status read and `dma_req` return 0x0000_0000.
- R2: A write to offset 0x4 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R3: A write to offset 0x8 sets each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: Status bits 0 and 1 always read 0, whatever is written at the set offset and whatever the packet-arrival inputs do.
- R5: When `dma_done[n]` is pulsed and `dma_en[n]` is 1, status bit n clears. When `dma_en[n]` is 0, the pulse has no effect.
- R6: When `pkt_arrive[n]` is pulsed, status bit n is set only if `int_en[n]` is 0. If `int_en[n]` is 1, the bit is unchanged.
- R7: Reads at offsets 0x4, 0x8 and any other offset except 0x0 return 0.
- R8: A write to offset 0x0 changes no status bit.
- R9: When a clear event (a software clear or a qualified completion) hits the same bit in the same cycle as a set event (a software set or a qualified arrival), the bit ends up 0.
- R10: A change made by a write or a hardware event at one rising edge can be seen on `bus_rdata` and `dma_req` before the next rising edge. `dma_req` always equals the status vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset: 0x0 status, 0x4 clear, 0x8 set |
| bus_wdata | input | 32 | Write data, one bit per endpoint |
| bus_rdata | output | 32 | Read data; 0 unless the status offset is read |
| pkt_arrive | input | 32 | Per-endpoint packet-arrival pulse |
| dma_done | input | 32 | Per-endpoint DMA packet-complete pulse |
| dma_en | input | 32 | Per-endpoint DMA enable |
| int_en | input | 32 | Per-endpoint slave interrupt enable |
| dma_req | output | 32 | Request vector to the DMA engine |

## Verification
Two functions can meet in one cycle. The first is a clear from software or from a completion, and the second is a raise from software or from packet arrival. Both can also land on a control bit. The bench provokes these collisions on purpose. In one cycle it writes the set register while a qualified completion pulses on the same bits. In another it writes the clear register while a qualified arrival pulses on those bits. The scoreboard then expects those bits to read back 0 while neighbouring bits hold their state. Arrivals and set writes aimed at bits 0 and 1 are judged by reading status and `dma_req` on the next cycle.

// File: rtl/edr_pkg.sv
package edr_pkg;
  localparam int unsigned NUM_EP   = 32;
  localparam int unsigned CTRL_EP  = 2;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_SET  = 4'h8;

  typedef struct packed {
    logic clr_sel;
    logic set_sel;
    logic stat_rd;
  } edr_sel_t;
endpackage

// File: rtl/edr_rst_sync.sv
module edr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/edr_bus_decode.sv
module edr_bus_decode
  import edr_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output edr_sel_t          sel
);
  always_comb begin
    sel.clr_sel = bus_wr && (bus_addr == OFS_CLR);
    sel.set_sel = bus_wr && (bus_addr == OFS_SET);
    sel.stat_rd = bus_rd && (bus_addr == OFS_STAT);
  end
endmodule

// File: rtl/edr_req_cell.sv
module edr_req_cell #(
  parameter bit FORCE_ZERO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_sw,
  input  logic raise_hw,
  input  logic drop_sw,
  input  logic drop_hw,
  output logic req_q
);
  logic req_d;
  logic req_en;
  logic drop_any;
  logic raise_any;

  always_comb begin
    drop_any  = drop_sw | drop_hw;
    raise_any = raise_sw | raise_hw;
    req_en    = drop_any | raise_any;
    if (FORCE_ZERO) req_d = 1'b0;
    else            req_d = (req_q | raise_any) & ~drop_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end
endmodule

// File: rtl/edr_top.sv
module edr_top
  import edr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_EP-1:0] bus_wdata,
  output logic [NUM_EP-1:0] bus_rdata,
  input  logic [NUM_EP-1:0] pkt_arrive,
  input  logic [NUM_EP-1:0] dma_done,
  input  logic [NUM_EP-1:0] dma_en,
  input  logic [NUM_EP-1:0] int_en,
  output logic [NUM_EP-1:0] dma_req
);
  logic              rst_q_n;
  edr_sel_t          sel;
  logic [NUM_EP-1:0] sw_set;
  logic [NUM_EP-1:0] sw_clr;
  logic [NUM_EP-1:0] hw_raise;
  logic [NUM_EP-1:0] hw_drop;
  logic [NUM_EP-1:0] status;

  edr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  edr_bus_decode u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  always_comb begin
    sw_set   = {NUM_EP{sel.set_sel}} & bus_wdata;
    sw_clr   = {NUM_EP{sel.clr_sel}} & bus_wdata;
    hw_raise = pkt_arrive & ~int_en;
    hw_drop  = dma_done & dma_en;
  end

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    edr_req_cell #(.FORCE_ZERO(n < CTRL_EP)) u_cell (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .raise_sw (sw_set[n]),
      .raise_hw (hw_raise[n]),
      .drop_sw  (sw_clr[n]),
      .drop_hw  (hw_drop[n]),
      .req_q    (status[n])
    );
  end

  always_comb begin
    bus_rdata = sel.stat_rd ? status : '0;
    dma_req   = status;
  end
endmodule

// File: rtl/edr_checker.sv
module edr_checker
  import edr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_EP-1:0] bus_wdata,
  input logic [NUM_EP-1:0] bus_rdata,
  input logic [NUM_EP-1:0] pkt_arrive,
  input logic [NUM_EP-1:0] dma_done,
  input logic [NUM_EP-1:0] dma_en,
  input logic [NUM_EP-1:0] int_en,
  input logic [NUM_EP-1:0] dma_req
);
  logic [NUM_EP-1:0] up_cause;
  assign up_cause = ((bus_wr && bus_addr == OFS_SET) ? bus_wdata : '0)
                  | (pkt_arrive & ~int_en);

  p_ctrl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[CTRL_EP-1:0] == '0);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLR) |=> ((dma_req & $past(bus_wdata)) == '0));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SET && (dma_done & dma_en) == '0)
      |=> ((~dma_req & $past(bus_wdata) & ~{{(NUM_EP-CTRL_EP){1'b0}}, {CTRL_EP{1'b1}}}) == '0));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_done & dma_en) != '0) |=> ((dma_req & $past(dma_done & dma_en)) == '0));

  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_req & ~$past(dma_req) & ~$past(up_cause)) == '0));

  p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != OFS_STAT) |-> (bus_rdata == '0));

  p_stat_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT && pkt_arrive == '0 && dma_done == '0)
      |=> $stable(dma_req));
endmodule

bind edr_top edr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pkt_arrive (pkt_arrive),
  .dma_done   (dma_done),
  .dma_en     (dma_en),
  .int_en     (int_en),
  .dma_req    (dma_req)
);

// File: tb/tb_edr_top.sv
module tb_edr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pkt_arrive;
  logic [31:0] dma_done;
  logic [31:0] dma_en;
  logic [31:0] int_en;
  logic [31:0] dma_req;

  typedef struct {
    logic [31:0] exp_rd;
    logic [31:0] exp_req;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model;
  int          checks;
  int          failures;
  bit          done_flag;

  edr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pkt_arrive(pkt_arrive), .dma_done(dma_done), .dma_en(dma_en),
    .int_en(int_en), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Drive one cycle of stimulus and advance the requirement model.
  task automatic op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                    input logic [31:0] arr, input logic [31:0] dn);
    logic [31:0] up;
    logic [31:0] down;
    @(negedge clk);
    bus_wr = wr; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    pkt_arrive = arr; dma_done = dn;
    up   = ((wr && a == 4'h8) ? d : 32'h0) | (arr & ~int_en);   // R3 R6
    down = ((wr && a == 4'h4) ? d : 32'h0) | (dn & dma_en);     // R2 R5
    model = (model | up) & ~down & ~32'h3;                      // R9 R4
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_wdata = 32'h0;
    pkt_arrive = 32'h0; dma_done = 32'h0;
    it.exp_rd  = (a == 4'h0) ? model : 32'h0;
    it.exp_req = model;
    it.tag     = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: pops expected items as reads occur.
  always @(negedge clk) begin
    #2;
    if (bus_rd && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp_rd) begin
        failures++;
        $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp_rd);
      end
      checks++;
      if (dma_req !== it.exp_req) begin
        failures++;
        $display("FAIL %s dma_req actual=%h expected=%h", it.tag, dma_req, it.exp_req);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done_flag = 0; model = 32'h0;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    pkt_arrive = 0; dma_done = 0; dma_en = 0; int_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(4'h0, "R1 reset status");
    op(1, 4'h8, 32'hF0F0_000F, 0, 0);
    rd(4'h0, "R3 R4 R10 set write");
    rd(4'h4, "R7 clear offset read");
    rd(4'h8, "R7 set offset read");
    rd(4'hC, "R7 unmapped read");
    op(1, 4'h4, 32'h0000_0004, 0, 0);
    rd(4'h0, "R2 clear one bit");
    op(1, 4'h4, 32'h0, 0, 0);
    rd(4'h0, "R2 clear zero no effect");
    op(1, 4'h8, 32'h0, 0, 0);
    rd(4'h0, "R3 set zero no effect");
    op(1, 4'h0, 32'hFFFF_FFFF, 0, 0);
    rd(4'h0, "R8 status write ignored");
    op(1, 4'h0, 32'h0, 0, 0);
    rd(4'h0, "R8 status write zero ignored");

    int_en = 32'h0000_FF00;
    op(0, 4'h0, 0, 32'h0000_FF03, 0);
    rd(4'h0, "R6 R4 arrival gated by int_en");
    int_en = 32'h0;
    op(0, 4'h0, 0, 32'h0000_0300, 0);
    rd(4'h0, "R6 arrival raises");

    dma_en = 32'h0;
    op(0, 4'h0, 0, 0, 32'hF000_0000);
    rd(4'h0, "R5 done without dma_en ignored");
    dma_en = 32'h3000_0000;
    op(0, 4'h0, 0, 0, 32'hF000_0000);
    rd(4'h0, "R5 done clears enabled");

    dma_en = 32'h00F0_0000;
    op(1, 4'h8, 32'h00FF_0000, 0, 32'h00F0_0000);
    rd(4'h0, "R9 set vs completion");
    op(1, 4'h4, 32'h0000_0F00, 32'h0000_FF00, 0);
    rd(4'h0, "R9 clear vs arrival");
    op(1, 4'h8, 32'hFFFF_FFFF, 0, 0);
    rd(4'h0, "R4 R10 set all");
    op(1, 4'h4, 32'hFFFF_FFFF, 0, 0);
    rd(4'h0, "R2 clear all");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R10 scoreboard actual=%0d expected=0", sb_q.size());
    end
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule